// File: doc/BRIEF.md
# Two-Wire Bus Start/Stop Condition Generator

This block forms a start or a stop condition on a two-wire open-drain bus, whatever state the clock and data lines are in when the request arrives. It drives only the data line, through a pull-low enable. When the clock must change, it asks a separate clock generator for a falling or a rising edge. It works out the clock level from the edge pulses that the generator's edge detector reports.

Each request runs a short sequence: clock low, data to the level that comes before the condition, clock high, then the data edge that forms the condition. Steps that the present line levels already satisfy are skipped. Each step that changes the data line is followed by a programmable wait. While the sequence runs, the block watches the start and stop pulses from an external condition detector. If another master produces a condition before this block makes its own, the sequence is abandoned and an early-condition pulse is raised.

All pins are plain control and status signals. No data stream crosses the block's edge, so there is no valid/ready back-pressure. A request is a one-cycle pulse and is accepted only while the block is idle.

Top module: `bus_cond_gen`

## Requirements
- R1: After reset the data line is released (`sda_pull_o` = 0), no clock edge is requested, and `done_o` and `early_o` are low. The clock is assumed high.
- R2: A start is data going high to low while the clock is high, and a stop is data going low to high while the clock is high. Each completed request produces exactly one such transition on the bus, of the requested kind.
- R3: If the clock is high and the data line already sits at the level that must precede the condition, no clock edge is requested. `done_o` then pulses WAIT_CYCLES cycles after the clock edge that sampled the request.
- R4: If the clock is high and the data line is at the wrong level, the block requests a falling clock edge. It changes the data line only after the delayed falling pulse, then requests a rising edge.
- R5: If the clock is already low (a delayed falling pulse has been seen and no rising pulse since), no falling edge is requested and the sequence goes on with the data step and the rising request.
- R6: After a start the data line is held low. After a stop the data line is released and the clock is left high.
- R7: `clk_fall_req_o` and `clk_rise_req_o` are never high together. The block never drives the clock line itself.
- R8: Start and stop requests that arrive while a sequence is in progress are ignored.
- R9: A detected start or stop on the bus before the block's own condition edge produces a one-cycle `early_o`. The sequence ends with no `done_o`, and all clock requests drop.
- R10: `done_o` is a one-cycle pulse, is never high together with `early_o`, and comes with no clock request pending.
- R11: If start and stop are requested in the same cycle, a start is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sda_i | input | 1 | Present data line level |
| scl_rise_i | input | 1 | One-cycle pulse: clock line rose |
| scl_fall_i | input | 1 | One-cycle pulse: clock line fell |
| scl_fall_late_i | input | 1 | One-cycle pulse: delayed copy of the clock falling pulse |
| cond_start_seen_i | input | 1 | One-cycle pulse: a start condition was detected on the bus |
| cond_stop_seen_i | input | 1 | One-cycle pulse: a stop condition was detected on the bus |
| make_start_i | input | 1 | Request a start condition (one-cycle pulse) |
| make_stop_i | input | 1 | Request a stop condition (one-cycle pulse) |
| sda_pull_o | output | 1 | Pull the data line low |
| clk_fall_req_o | output | 1 | Ask the clock generator for a falling edge |
| clk_rise_req_o | output | 1 | Ask the clock generator for a rising edge |
| early_o | output | 1 | One-cycle pulse: another condition came before this block's own |
| done_o | output | 1 | One-cycle pulse: the requested condition has been formed |

## Verification
The assertions check, on every cycle, that the two clock requests never overlap. They also check that `done_o` and `early_o` are isolated one-cycle pulses that never coincide, and that neither pulse is left with a clock request still pending. Only the bench's scenarios can show the line-level behaviour. That covers which steps are skipped for each starting state of the lines, and that the data line moves only while the clock is low, except for the one edge that forms the condition. It also covers that exactly one condition of the requested kind appears, that a start wins over a stop, and that a request made mid-sequence or a foreign condition is handled correctly. A bus model in the bench answers the clock requests and detects conditions, which provides these observations.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_FALL   = 3'd1,
    SQ_PREP   = 3'd2,
    SQ_RISE   = 3'd3,
    SQ_SETTLE = 3'd4,
    SQ_EDGE   = 3'd5
  } seq_state_e;

endpackage

// File: rtl/bcg_clk_track.sv
module bcg_clk_track (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic fall_i,
  input  logic fall_late_i,
  output logic low_o,
  output logic safe_o
);

  logic low_q, safe_q;

  // low: clock seen falling; safe: delayed falling seen, data may move
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= 1'b0;
      safe_q <= 1'b0;
    end else begin
      if (rise_i) begin
        low_q  <= 1'b0;
        safe_q <= 1'b0;
      end else begin
        if (fall_i)      low_q  <= 1'b1;
        if (fall_late_i) begin
          low_q  <= 1'b1;
          safe_q <= 1'b1;
        end
      end
    end
  end

  assign low_o  = low_q;
  assign safe_o = safe_q;

endmodule

// File: rtl/bcg_wait_timer.sv
module bcg_wait_timer #(
  parameter int unsigned WAIT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  output logic expired_o
);

  localparam int unsigned CW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign expired_o = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clear_i)    cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/bcg_seq_fsm.sv
module bcg_seq_fsm
  import bcg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sda_i,
  input  logic rise_i,
  input  logic fall_late_i,
  input  logic low_i,
  input  logic safe_i,
  input  logic cond_i,
  input  logic make_start_i,
  input  logic make_stop_i,
  input  logic expired_i,
  output logic timer_clr_o,
  output logic sda_pull_o,
  output logic req_fall_o,
  output logic req_rise_o,
  output logic early_o,
  output logic done_o
);

  seq_state_e state_q, state_d;
  logic stop_q, stop_d;
  logic pull_q, pull_d;
  logic early_q, early_d;
  logic done_q, done_d;
  logic pre_ok;

  // data already at the level that must precede the condition edge
  assign pre_ok = (sda_i == !stop_d);

  always_comb begin
    state_d = state_q;
    stop_d  = stop_q;
    pull_d  = pull_q;
    early_d = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (make_start_i || make_stop_i) begin
          stop_d = !make_start_i;
          if (!low_i && pre_ok) begin
            state_d = SQ_EDGE;
            pull_d  = !stop_d;
          end else if (safe_i) begin
            if (pre_ok) begin
              state_d = SQ_RISE;
            end else begin
              state_d = SQ_PREP;
              pull_d  = stop_d;
            end
          end else begin
            state_d = SQ_FALL;
          end
        end
      end
      SQ_FALL: begin
        if (safe_i || fall_late_i) begin
          state_d = SQ_PREP;
          pull_d  = stop_q;
        end
      end
      SQ_PREP: begin
        if (expired_i) state_d = SQ_RISE;
      end
      SQ_RISE: begin
        if (rise_i || !low_i) state_d = SQ_SETTLE;
      end
      SQ_SETTLE: begin
        if (expired_i) begin
          state_d = SQ_EDGE;
          pull_d  = !stop_q;
        end
      end
      SQ_EDGE: begin
        if (expired_i) begin
          state_d = SQ_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
    // a foreign condition before our own edge abandons the sequence
    if (cond_i && (state_q inside {SQ_FALL, SQ_PREP, SQ_RISE, SQ_SETTLE})) begin
      state_d = SQ_IDLE;
      pull_d  = pull_q;
      early_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      stop_q  <= 1'b0;
      pull_q  <= 1'b0;
      early_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      stop_q  <= stop_d;
      pull_q  <= pull_d;
      early_q <= early_d;
      done_q  <= done_d;
    end
  end

  assign timer_clr_o = (state_d != state_q);
  assign sda_pull_o  = pull_q;
  assign req_fall_o  = (state_q == SQ_FALL) && !low_i;
  assign req_rise_o  = (state_q == SQ_RISE) && low_i;
  assign early_o     = early_q;
  assign done_o      = done_q;

endmodule

// File: rtl/bus_cond_gen.sv
module bus_cond_gen #(
  parameter int unsigned WAIT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_i,
  input  logic scl_rise_i,
  input  logic scl_fall_i,
  input  logic scl_fall_late_i,
  input  logic cond_start_seen_i,
  input  logic cond_stop_seen_i,
  input  logic make_start_i,
  input  logic make_stop_i,
  output logic sda_pull_o,
  output logic clk_fall_req_o,
  output logic clk_rise_req_o,
  output logic early_o,
  output logic done_o
);

  logic clk_low, clk_safe, tmr_clr, tmr_exp, cond_any;

  assign cond_any = cond_start_seen_i || cond_stop_seen_i;

  bcg_clk_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_i     (scl_rise_i),
    .fall_i     (scl_fall_i),
    .fall_late_i(scl_fall_late_i),
    .low_o      (clk_low),
    .safe_o     (clk_safe)
  );

  bcg_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (tmr_clr),
    .expired_o(tmr_exp)
  );

  bcg_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sda_i       (sda_i),
    .rise_i      (scl_rise_i),
    .fall_late_i (scl_fall_late_i),
    .low_i       (clk_low),
    .safe_i      (clk_safe),
    .cond_i      (cond_any),
    .make_start_i(make_start_i),
    .make_stop_i (make_stop_i),
    .expired_i   (tmr_exp),
    .timer_clr_o (tmr_clr),
    .sda_pull_o  (sda_pull_o),
    .req_fall_o  (clk_fall_req_o),
    .req_rise_o  (clk_rise_req_o),
    .early_o     (early_o),
    .done_o      (done_o)
  );

endmodule

// File: rtl/bus_cond_gen_chk.sv
module bus_cond_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic clk_fall_req_o,
  input logic clk_rise_req_o,
  input logic early_o,
  input logic done_o
);

  // R7
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clk_fall_req_o, clk_rise_req_o}));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  done_early_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && early_o));

  // R10
  done_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(clk_fall_req_o || clk_rise_req_o));

  // R9
  early_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    early_o |=> !early_o);

  // R9
  early_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    early_o |-> !(clk_fall_req_o || clk_rise_req_o));

endmodule

bind bus_cond_gen bus_cond_gen_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .clk_fall_req_o(clk_fall_req_o),
  .clk_rise_req_o(clk_rise_req_o),
  .early_o       (early_o),
  .done_o        (done_o)
);

// File: tb/test_bus_cond_gen.sv
module test_bus_cond_gen;

  localparam int WAIT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl_m = 1'b1;
  logic rise_p = 1'b0, fall_p = 1'b0, late_p = 1'b0, st_p = 1'b0, sp_p = 1'b0;
  logic mk_start = 1'b0, mk_stop = 1'b0;
  logic sda_pull, rq_fall, rq_rise, early, done;
  wire  sda_line = !sda_pull;

  bus_cond_gen #(.WAIT_CYCLES(WAIT)) i_bus_cond_gen (
    .clk              (clk),
    .rst_n            (rst_n),
    .sda_i            (sda_line),
    .scl_rise_i       (rise_p),
    .scl_fall_i       (fall_p),
    .scl_fall_late_i  (late_p),
    .cond_start_seen_i(st_p),
    .cond_stop_seen_i (sp_p),
    .make_start_i     (mk_start),
    .make_stop_i      (mk_stop),
    .sda_pull_o       (sda_pull),
    .clk_fall_req_o   (rq_fall),
    .clk_rise_req_o   (rq_rise),
    .early_o          (early),
    .done_o           (done)
  );

  int total = 0, bad = 0;
  int n_done = 0, n_early = 0, n_start = 0, n_stop = 0, viol = 0, phase = 0;
  bit saw_fall = 0, saw_rise = 0, late_seen = 0, hold_scl = 0, ext_fall = 0, inj_start = 0;
  logic prev_line = 1'b1, prev_pull = 1'b0;

  // bus model: clock generator, condition detector, observers (on negedge)
  initial begin
    forever begin
      @(negedge clk);
      rise_p = 0; fall_p = 0; late_p = 0; st_p = 0; sp_p = 0;
      if (rst_n) begin
        if (scl_m && prev_line && !sda_line) begin st_p = 1; n_start++; end
        if (scl_m && !prev_line && sda_line) begin sp_p = 1; n_stop++; end
        if (!scl_m && (sda_pull !== prev_pull) && !late_seen) viol++;
        if (inj_start) begin st_p = 1; inj_start = 0; end
        if (done) n_done++;
        if (early) n_early++;
        if (rq_fall) saw_fall = 1;
        if (rq_rise) saw_rise = 1;
        case (phase)
          0: if ((rq_fall || ext_fall) && scl_m) begin phase = 1; ext_fall = 0; end
          1: begin scl_m = 0; fall_p = 1; phase = 2; end
          2: phase = 3;
          3: begin late_p = 1; late_seen = 1; phase = 0; end
          default: phase = 0;
        endcase
        if (phase == 0 && rq_rise && !scl_m && !hold_scl) begin
          scl_m = 1; rise_p = 1; late_seen = 0;
        end
      end
      prev_line = sda_line;
      prev_pull = sda_pull;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // mode 1: extra start request at cycle 'at'; mode 2: foreign start at cycle 'at'
  task automatic issue(bit s, bit p, int mode, int at, output int lat);
    @(negedge clk); #1;
    n_done = 0; n_early = 0; n_start = 0; n_stop = 0; viol = 0;
    saw_fall = 0; saw_rise = 0;
    mk_start = s; mk_stop = p;
    @(posedge clk); #1;
    mk_start = 0; mk_stop = 0;
    lat = -1;
    for (int i = 1; i <= 400; i++) begin
      @(posedge clk); #1;
      if (mode == 1) mk_start = (i == at);
      if (mode == 2 && i == at) inj_start = 1;
      if (done || early) begin lat = i; break; end
    end
    mk_start = 0;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic clock_low_externally();
    @(negedge clk); #1;
    ext_fall = 1;
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R1", "sda_pull", sda_pull, 0);
    chk("R1", "fall req", rq_fall, 0);
    chk("R1", "rise req", rq_rise, 0);
    chk("R1", "done/early", done | early, 0);
  endtask

  task automatic t_start_idle();
    int lat;
    issue(1, 0, 0, 0, lat);
    chk("R3", "start latency", lat, WAIT);
    chk("R3", "fall requested", saw_fall, 0);
    chk("R2", "starts seen", n_start, 1);
    chk("R2", "stops seen", n_stop, 0);
    chk("R6", "sda held after start", sda_pull, 1);
    chk("R10", "done count", n_done, 1);
  endtask

  task automatic t_stop_after_start();
    int lat;
    issue(0, 1, 0, 0, lat);
    chk("R3", "stop latency", lat, WAIT);
    chk("R3", "fall requested", saw_fall, 0);
    chk("R2", "stops seen", n_stop, 1);
    chk("R6", "sda released after stop", sda_pull, 0);
  endtask

  task automatic t_stop_idle_ignored();
    int lat;
    issue(0, 1, 1, 2, lat);
    chk("R4", "fall requested", saw_fall, 1);
    chk("R4", "rise requested", saw_rise, 1);
    chk("R4", "data moved before late fall", viol, 0);
    chk("R8", "stops seen", n_stop, 1);
    chk("R8", "starts seen", n_start, 0);
    chk("R8", "done count", n_done, 1);
    chk("R6", "sda released", sda_pull, 0);
    chk("R6", "clock high", scl_m, 1);
  endtask

  task automatic t_both();
    int lat;
    issue(1, 1, 0, 0, lat);
    chk("R11", "starts seen", n_start, 1);
    chk("R11", "stops seen", n_stop, 0);
    chk("R11", "sda held", sda_pull, 1);
  endtask

  task automatic t_repeat_start();
    int lat;
    issue(1, 0, 0, 0, lat);
    chk("R4", "fall requested", saw_fall, 1);
    chk("R4", "data moved before late fall", viol, 0);
    chk("R2", "repeated start seen", n_start, 1);
    chk("R2", "stops seen", n_stop, 0);
    chk("R6", "sda held", sda_pull, 1);
  endtask

  task automatic t_start_clk_low();
    int lat;
    clock_low_externally();
    issue(1, 0, 0, 0, lat);
    chk("R5", "fall requested", saw_fall, 0);
    chk("R5", "rise requested", saw_rise, 1);
    chk("R5", "starts seen", n_start, 1);
    chk("R5", "sda held", sda_pull, 1);
  endtask

  task automatic t_early();
    int lat;
    clock_low_externally();
    hold_scl = 1;
    issue(1, 0, 2, 2, lat);
    chk("R9", "early count", n_early, 1);
    chk("R9", "done count", n_done, 0);
    chk("R9", "rise req after abort", rq_rise, 0);
    chk("R9", "own starts", n_start, 0);
    hold_scl = 0;
  endtask

  task automatic t_stop_clk_low();
    int lat;
    issue(0, 1, 0, 0, lat);
    chk("R5", "fall requested", saw_fall, 0);
    chk("R2", "stops seen", n_stop, 1);
    chk("R2", "starts seen", n_start, 0);
    chk("R6", "clock high", scl_m, 1);
    chk("R6", "sda released", sda_pull, 0);
    chk("R4", "data moved before late fall", viol, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    t_start_idle();
    t_stop_after_start();
    t_stop_idle_ignored();
    t_both();
    t_repeat_start();
    t_start_clk_low();
    t_early();
    t_stop_clk_low();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule